// File: doc/BRIEF.md
# Sensor Scratchpad with Alarm Comparator

This block holds the nine-byte register image of a digital temperature sensor. A host write port updates the three user bytes: the upper alarm threshold, the lower alarm threshold and the configuration byte. A byte-wide read port returns any of the nine bytes. Reads are registered and arrive one cycle after the address is presented.

A conversion port delivers 16-bit two's-complement results. Each result is stored with its undefined low-order bits cleared according to the configured resolution. On the same edge, bits 11:4 of the result are compared as a signed byte against both thresholds, and an alarm flag is updated.

Two strobes model nonvolatile storage. One copies the three user bytes into shadow registers. The other reloads the user bytes from those shadows. Reset performs the same reload from the shadow initial values. The check byte is taken from an external input at read time. The block also drives the resolution code and a conversion-time selector, which tell a conversion engine how long a measurement may take.

Top module: `sensor_scratchpad`

## Requirements
- R1: After reset, byte 0 reads 50h, byte 1 reads 05h, the resolution code is 2'b11, bytes 2 and 3 hold the threshold initial parameters, and alarm is 0.
- R2: A write with wr_addr 2, 3 or 4 updates the upper threshold, the lower threshold or the resolution code (wr_data[6:5]) respectively. The new value is visible from the next edge.
- R3: Writes to addresses 0, 1 and 5 to 15 change no stored byte.
- R4: Byte 4 reads {1, res[1:0], 5'b11111}. Bytes 5, 6 and 7 read FFh, 0Ch and 10h. Addresses 9 to 15 read 00h.
- R5: rd_data presents the byte at rd_addr one clock edge after it is sampled. Byte 8 returns crc_in as sampled at that edge.
- R6: When conv_valid is high, the result is stored with bit 0 cleared at code 10 (11 bits), bits 1:0 cleared at code 01 (10 bits), bits 2:0 cleared at code 00 (9 bits), and nothing cleared at code 11.
- R7: alarm is set when signed conv_temp[11:4] is greater than the signed upper threshold or less than the signed lower threshold. Equality with either threshold does not set it.
- R8: alarm and the stored temperature change only on an edge where conv_valid is high. A later in-range result clears alarm.
- R9: res_bits equals the stored resolution code, and conv_time_sel equals 3 minus that code. This is the number of halvings of the full 12-bit conversion time.
- R10: copy_req saves the three user bytes into shadow registers. recall_req reloads them, and a recall takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Byte address of the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Byte address of the read |
| rd_data | output | 8 | Registered read data |
| crc_in | input | 8 | Check byte returned at address 8 |
| conv_valid | input | 1 | New conversion result strobe |
| conv_temp | input | 16 | Two's-complement conversion result |
| copy_req | input | 1 | Save user bytes to shadow registers |
| recall_req | input | 1 | Reload user bytes from shadow registers |
| res_bits | output | 2 | Resolution code (00=9 bits to 11=12 bits) |
| conv_time_sel | output | 2 | Conversion-time halvings (0 = full time) |
| alarm | output | 1 | Alarm flag from the last conversion |

## Verification
Read data is due one edge after rd_addr is sampled. The stored temperature and the alarm flag are due one edge after conv_valid. The resolution outputs and the user bytes are due one edge after a write, copy or recall. The bench changes every input on the falling edge and compares outputs on the following falling edge, so each comparison falls between the edge that produced the value and the next one. Random writes, conversions, reads and shadow operations are checked against a bench model. Directed cases cover threshold equality, negative slices, each masking width and a same-cycle write with recall.

// File: rtl/spad_pkg.sv
package spad_pkg;
  localparam int BYTE_W      = 8;
  localparam int TEMP_W      = 16;
  localparam int LOW_BITS    = 3;
  localparam int SLICE_LSB   = 4;
  localparam logic [7:0] RSV5_VAL = 8'hFF;
  localparam logic [7:0] RSV6_VAL = 8'h0C;
  localparam logic [7:0] RSV7_VAL = 8'h10;
  localparam logic [7:0] OPEN_VAL = 8'h00;

  typedef enum logic [3:0] {
    A_TLO = 4'd0, A_THI = 4'd1, A_UPPER = 4'd2, A_LOWER = 4'd3,
    A_CFG = 4'd4, A_RSV5 = 4'd5, A_RSV6 = 4'd6, A_RSV7 = 4'd7,
    A_CHK = 4'd8
  } spad_addr_e;

  function automatic logic [7:0] cfg_image(input logic [1:0] res);
    return {1'b1, res, 5'b11111};
  endfunction
endpackage

// File: rtl/spad_cfg_store.sv
module spad_cfg_store #(
  parameter int ADDR_W = 4,
  parameter logic [7:0] UPPER_INIT = 8'h4B,
  parameter logic [7:0] LOWER_INIT = 8'h05,
  parameter logic [1:0] RES_INIT = 2'b11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              copy_req,
  input  logic              recall_req,
  output logic [7:0]        upper_q,
  output logic [7:0]        lower_q,
  output logic [1:0]        res_q
);
  import spad_pkg::*;

  logic [7:0] sh_upper, sh_lower;
  logic [1:0] sh_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_upper <= UPPER_INIT;
      sh_lower <= LOWER_INIT;
      sh_res   <= RES_INIT;
    end else if (copy_req) begin
      sh_upper <= upper_q;
      sh_lower <= lower_q;
      sh_res   <= res_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= UPPER_INIT;
      lower_q <= LOWER_INIT;
      res_q   <= RES_INIT;
    end else if (recall_req) begin
      upper_q <= sh_upper;
      lower_q <= sh_lower;
      res_q   <= sh_res;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(A_UPPER): upper_q <= wr_data;
        ADDR_W'(A_LOWER): lower_q <= wr_data;
        ADDR_W'(A_CFG):   res_q   <= wr_data[6:5];
        default: ;
      endcase
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!recall_req && !(wr_en && (wr_addr == ADDR_W'(A_UPPER) || wr_addr == ADDR_W'(A_LOWER) || wr_addr == ADDR_W'(A_CFG))))
    |=> ($stable(upper_q) && $stable(lower_q) && $stable(res_q))); // R3
  AST_RECALL_WINS: assert property (@(posedge clk) disable iff (rst)
    (recall_req && wr_en) |=> (upper_q == $past(sh_upper) && res_q == $past(sh_res))); // R10
endmodule

// File: rtl/spad_temp_capture.sv
module spad_temp_capture #(
  parameter int TEMP_W = 16,
  parameter logic [TEMP_W-1:0] TEMP_INIT = 16'h0550
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_valid,
  input  logic [TEMP_W-1:0] conv_temp,
  input  logic [1:0]        res,
  input  logic [7:0]        upper,
  input  logic [7:0]        lower,
  output logic [TEMP_W-1:0] temp_q,
  output logic              alarm_q
);
  import spad_pkg::*;

  logic [TEMP_W-1:0] keep_mask;
  logic signed [7:0] slice;
  logic              hit;

  // bit i of the result survives when res >= LOW_BITS - i
  for (genvar i = 0; i < TEMP_W; i++) begin : g_mask
    if (i < LOW_BITS) begin : g_low
      assign keep_mask[i] = ({1'b0, res} >= 3'(LOW_BITS - i));
    end else begin : g_high
      assign keep_mask[i] = 1'b1;
    end
  end

  assign slice = $signed(conv_temp[SLICE_LSB +: 8]);
  assign hit   = (slice > $signed(upper)) || (slice < $signed(lower));

  always_ff @(posedge clk) begin
    if (rst) begin
      temp_q  <= TEMP_INIT;
      alarm_q <= 1'b0;
    end else if (conv_valid) begin
      temp_q  <= conv_temp & keep_mask;
      alarm_q <= hit;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !conv_valid |=> ($stable(alarm_q) && $stable(temp_q))); // R8
  AST_EQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && $signed(conv_temp[11:4]) == $signed(upper) && $signed(conv_temp[11:4]) >= $signed(lower))
    |=> !alarm_q); // R7
  AST_ABOVE_ALARM: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && $signed(conv_temp[11:4]) > $signed(upper)) |=> alarm_q); // R7
  AST_MASK9: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && res == 2'b00) |=> (temp_q[2:0] == 3'b000)); // R6
endmodule

// File: rtl/sensor_scratchpad.sv
module sensor_scratchpad #(
  parameter int ADDR_W = 4,
  parameter logic [7:0] UPPER_INIT = 8'h4B,
  parameter logic [7:0] LOWER_INIT = 8'h05,
  parameter logic [1:0] RES_INIT = 2'b11,
  parameter logic [15:0] TEMP_INIT = 16'h0550
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic [7:0]        crc_in,
  input  logic              conv_valid,
  input  logic [15:0]       conv_temp,
  input  logic              copy_req,
  input  logic              recall_req,
  output logic [1:0]        res_bits,
  output logic [1:0]        conv_time_sel,
  output logic              alarm
);
  import spad_pkg::*;

  logic [7:0]  upper_q, lower_q;
  logic [1:0]  res_q;
  logic [15:0] temp_q;
  logic [7:0]  rd_next;

  spad_cfg_store #(
    .ADDR_W(ADDR_W), .UPPER_INIT(UPPER_INIT),
    .LOWER_INIT(LOWER_INIT), .RES_INIT(RES_INIT)
  ) cfg_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .copy_req(copy_req), .recall_req(recall_req),
    .upper_q(upper_q), .lower_q(lower_q), .res_q(res_q)
  );

  spad_temp_capture #(.TEMP_W(16), .TEMP_INIT(TEMP_INIT)) cap_i (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_temp(conv_temp),
    .res(res_q), .upper(upper_q), .lower(lower_q),
    .temp_q(temp_q), .alarm_q(alarm)
  );

  assign res_bits      = res_q;
  assign conv_time_sel = ~res_q;

  always_comb begin
    case (rd_addr)
      ADDR_W'(A_TLO):   rd_next = temp_q[7:0];
      ADDR_W'(A_THI):   rd_next = temp_q[15:8];
      ADDR_W'(A_UPPER): rd_next = upper_q;
      ADDR_W'(A_LOWER): rd_next = lower_q;
      ADDR_W'(A_CFG):   rd_next = cfg_image(res_q);
      ADDR_W'(A_RSV5):  rd_next = RSV5_VAL;
      ADDR_W'(A_RSV6):  rd_next = RSV6_VAL;
      ADDR_W'(A_RSV7):  rd_next = RSV7_VAL;
      ADDR_W'(A_CHK):   rd_next = crc_in;
      default:          rd_next = OPEN_VAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= OPEN_VAL;
    else     rd_data <= rd_next;
  end

  AST_RSV5_FIXED: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_W'(5)) |=> (rd_data == 8'hFF)); // R4
  AST_CHK_PASS: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_W'(8)) |=> (rd_data == $past(crc_in))); // R5
  AST_CFG_ONES: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_W'(4)) |=> (rd_data[7] && rd_data[4:0] == 5'b11111)); // R4
endmodule

// File: tb/sensor_scratchpad_tb.sv
module sensor_scratchpad_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] UP0 = 8'h4B;
  localparam logic [7:0] LO0 = 8'h05;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, conv_valid = 1'b0, copy_req = 1'b0, recall_req = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, crc_in = '0, rd_data;
  logic [15:0] conv_temp = '0;
  logic [1:0] res_bits, conv_time_sel;
  logic alarm;

  int checks = 0, failures = 0;
  logic done = 1'b0;

  // bench model
  logic [7:0] m_up, m_lo, s_up, s_lo;
  logic [1:0] m_res, s_res;
  logic [15:0] m_temp;
  logic m_alarm;

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_scratchpad dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .crc_in(crc_in),
    .conv_valid(conv_valid), .conv_temp(conv_temp),
    .copy_req(copy_req), .recall_req(recall_req),
    .res_bits(res_bits), .conv_time_sel(conv_time_sel), .alarm(alarm)
  );

  function automatic logic [15:0] exp_mask(input logic [15:0] t, input logic [1:0] r);
    case (r)
      2'b00: return {t[15:3], 3'b000};
      2'b01: return {t[15:2], 2'b00};
      2'b10: return {t[15:1], 1'b0};
      default: return t;
    endcase
  endfunction

  function automatic logic exp_alarm(input logic [15:0] t, input logic [7:0] u, input logic [7:0] l);
    int v, uu, ll;
    v  = int'($signed(t[11:4]));
    uu = int'($signed(u));
    ll = int'($signed(l));
    return (v > uu) || (v < ll);
  endfunction

  function automatic logic [7:0] exp_byte(input logic [3:0] a, input logic [7:0] crc);
    case (a)
      4'd0: return m_temp[7:0];
      4'd1: return m_temp[15:8];
      4'd2: return m_up;
      4'd3: return m_lo;
      4'd4: return {1'b1, m_res, 5'b11111};
      4'd5: return 8'hFF;
      4'd6: return 8'h0C;
      4'd7: return 8'h10;
      4'd8: return crc;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; conv_valid = 0; copy_req = 0; recall_req = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle_inputs();
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    case (a)
      4'd2: m_up = d;
      4'd3: m_lo = d;
      4'd4: m_res = d[6:5];
      default: ;
    endcase
  endtask

  task automatic do_conv(input logic [15:0] t, input string req);
    conv_valid = 1; conv_temp = t;
    step();
    m_temp = exp_mask(t, m_res);
    m_alarm = exp_alarm(t, m_up, m_lo);
    check(req, {15'd0, alarm}, {15'd0, m_alarm});
  endtask

  task automatic do_read(input logic [3:0] a, input string req);
    logic [7:0] c;
    c = 8'($urandom);
    rd_addr = a; crc_in = c;
    step();
    check(req, {8'd0, rd_data}, {8'd0, exp_byte(a, c)});
  endtask

  task automatic check_res(input string req);
    check(req, {14'd0, res_bits}, {14'd0, m_res});
    check(req, {14'd0, conv_time_sel}, {14'd0, 2'(3 - m_res)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_val;
    seed_val = $urandom(32'h5EED_0042);
    m_up = UP0; m_lo = LO0; m_res = 2'b11; m_temp = 16'h0550; m_alarm = 0;
    s_up = UP0; s_lo = LO0; s_res = 2'b11;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    check("R1 alarm", {15'd0, alarm}, 16'd0);
    check("R1 res", {14'd0, res_bits}, 16'd3);
    do_read(4'd0, "R1 temp lsb");
    do_read(4'd1, "R1 temp msb");
    do_read(4'd2, "R1 upper");
    do_read(4'd3, "R1 lower");
    // R4 fixed bytes and open addresses
    for (int a = 4; a < 16; a++) do_read(4'(a), "R4 fixed byte");
    // R5 check byte pass-through
    do_read(4'd8, "R5 crc");

    // R2 writes, R9 resolution outputs
    do_write(4'd2, 8'd20);
    do_write(4'd3, 8'hF6);
    do_read(4'd2, "R2 upper");
    do_read(4'd3, "R2 lower");
    for (int r = 0; r < 4; r++) begin
      do_write(4'd4, {1'b0, 2'(r), 5'b00000});
      check_res("R9 res outputs");
      do_read(4'd4, "R2 cfg image");
      // R6 masking at each resolution
      do_conv(16'h0157, "R6 conv alarm");
      do_read(4'd0, "R6 masked lsb");
      do_read(4'd1, "R6 msb");
    end

    // R3 ignored writes
    do_write(4'd0, 8'hAA);
    do_write(4'd1, 8'hBB);
    do_write(4'd5, 8'h00);
    do_write(4'd7, 8'h00);
    do_read(4'd0, "R3 temp lsb untouched");
    do_read(4'd1, "R3 temp msb untouched");
    do_read(4'd5, "R3 rsv untouched");
    do_read(4'd2, "R3 upper untouched");

    // R7 boundaries: upper 20 (0x14), lower -10 (0xF6)
    do_conv(16'h0140, "R7 equal upper no alarm");
    do_conv(16'h0150, "R7 above upper");
    do_conv(16'hFF60, "R7 equal lower no alarm");
    do_conv(16'hFF50, "R7 below lower");
    // R8 hold while idle, then clear
    step(); step();
    check("R8 hold", {15'd0, alarm}, 16'd1);
    do_conv(16'h0000, "R8 clear in range");

    // R10 copy, overwrite, recall; recall beats write
    do_write(4'd2, 8'h30); do_write(4'd3, 8'h80); do_write(4'd4, 8'h20);
    copy_req = 1; step();
    s_up = m_up; s_lo = m_lo; s_res = m_res;
    do_write(4'd2, 8'h01); do_write(4'd4, 8'h60);
    recall_req = 1; wr_en = 1; wr_addr = 4'd2; wr_data = 8'h77;
    step();
    m_up = s_up; m_lo = s_lo; m_res = s_res;
    do_read(4'd2, "R10 recall upper");
    do_read(4'd3, "R10 recall lower");
    check_res("R10 recall res");

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 3) begin
        logic [3:0] a;
        a = 4'($urandom_range(0, 8));
        do_write(a, 8'($urandom));
        if (a == 4'd4) check_res("R9 random res");
      end else if (op < 6) begin
        do_conv(16'($urandom), "R7 random alarm");
      end else if (op < 9) begin
        do_read(4'($urandom), "R6 random read");
      end else if ($urandom_range(0, 1) == 0) begin
        copy_req = 1; step();
        s_up = m_up; s_lo = m_lo; s_res = m_res;
      end else begin
        recall_req = 1; step();
        m_up = s_up; m_lo = s_lo; m_res = s_res;
        check_res("R10 random recall");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule